// File: doc/BRIEF.md
# Width-Parallel Tiled 3x3 Convolution Engine

This block computes one output tile of a 3x3, stride-1 convolution layer from small on-chip buffers. Software or a surrounding loader fills an input tile slice that already carries a one-pixel border (halo) on every side, the 3x3 weights for every filter of a kernel group and every channel of the slice, and one bias per filter. After a start pulse the engine sweeps filter by filter, channel by channel, row by row and tap by tap. A row of multiply-accumulate lanes, one per output column, updates a whole tile row in a single cycle.

Wide channel depths are handled by running the engine once per channel slice. Running sums stay in an internal partial buffer between runs. The first run of a tile is flagged so that each sum starts from the bias. The last run is flagged so that each finished row is rectified, clamped to the output width and streamed out as one wide word per row. A one-cycle completion strobe closes every run.

Top module: `conv_tile_engine`

## Requirements
- R1: After reset, `done` and `out_vld` are low and every running sum is zero, so a run with `first_slice`=0 starts from zero.
- R2: For filter f, row i and column j, a run adds the sum over slice channel c and taps t=0..8 of X[c][i+t/3][j+t%3]*W[f][c][t]. X is addressed in halo coordinates: buffer row 0 and column 0 are the border, and TH+1 and TW+1 are the far border. Tap t maps to kernel row t/3 and kernel column t%3.
- R3: With `first_slice`=1, each sum starts from the signed bias of its filter. With `first_slice`=0, it continues from the value left by the previous run, and the bias is not added.
- R4: Each streamed value is 0 for a negative sum, 32767 for a sum above 32767, and otherwise the sum itself.
- R5: A run with `last_slice`=1 emits exactly KG*TH `out_vld` strobes in filter-major, row-ascending order. Each strobe carries `out_filt`, `out_row` and column j in `out_data[16j+15:16j]`.
- R6: A run with `last_slice`=0 emits no `out_vld` strobe.
- R7: `done` is a single-cycle pulse. It rises exactly KG*CS*TH*9 clock edges after the edge that sampled `start`, and it coincides with the final row strobe when `last_slice`=1.
- R8: A `start` pulse during a run is ignored: it does not change the latency, the number of strobes or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled while idle) |
| first_slice | input | 1 | Run initialises sums from the bias |
| last_slice | input | 1 | Run streams rectified results |
| in_we | input | 1 | Input tile write enable |
| in_ch | input | 1 | Input tile channel index |
| in_row | input | 3 | Input tile row, halo coordinates |
| in_col | input | 3 | Input tile column, halo coordinates |
| in_data | input | 8 | Signed input sample |
| w_we | input | 1 | Weight write enable |
| w_filt | input | 1 | Weight filter index |
| w_ch | input | 1 | Weight channel index |
| w_tap | input | 4 | Weight tap index, 3*row+column |
| w_data | input | 8 | Signed weight |
| b_we | input | 1 | Bias write enable |
| b_filt | input | 1 | Bias filter index |
| b_data | input | 16 | Signed bias |
| done | output | 1 | Run completion pulse |
| out_vld | output | 1 | Finished output row strobe |
| out_filt | output | 1 | Filter of the streamed row |
| out_row | output | 2 | Tile row of the streamed row |
| out_data | output | 64 | TW clamped 16-bit results |

## Verification
The bench builds the engine with its defaults: a 4x4 tile, two channels per slice and two filters per group. With these sizes every halo cell reaches a border lane, and both filter and channel counters wrap within a 144-cycle run. Full-range 8-bit data summed over 18 taps per slice drives sums well past 32767 and below zero. Multi-slice chains then expose accumulation across runs and the bias-once rule.

// File: rtl/conv_pkg.sv
package conv_pkg;
    localparam int KDIM = 3;
    localparam int NTAP = KDIM * KDIM;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    typedef struct packed {
        logic first;
        logic last;
    } slice_mode_t;

    // kernel row of a tap index (taps numbered row-major)
    function automatic logic [1:0] tap_dy(input logic [3:0] t);
        return 2'(t / 4'd3);
    endfunction

    // kernel column of a tap index
    function automatic logic [1:0] tap_dx(input logic [3:0] t);
        return 2'(t % 4'd3);
    endfunction
endpackage

// File: rtl/mac_lane.sv
module mac_lane #(
    parameter int DW = 8,
    parameter int AW = 24,
    parameter int BW = 16
) (
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] w,
    input  logic signed [AW-1:0] acc,
    input  logic signed [BW-1:0] bias,
    input  logic                 init,
    output logic signed [AW-1:0] sum
);
    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   prod_ext;
    logic signed [AW-1:0]   base;

    assign prod     = x * w;
    assign prod_ext = {{(AW-2*DW){prod[2*DW-1]}}, prod};
    assign base     = init ? {{(AW-BW){bias[BW-1]}}, bias} : acc;
    assign sum      = base + prod_ext;
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_pkg::*;
#(
    parameter int KG = 2,
    parameter int CS = 2,
    parameter int TH = 4,
    localparam int FW = (KG > 1) ? $clog2(KG) : 1,
    localparam int CW = (CS > 1) ? $clog2(CS) : 1,
    localparam int HW = (TH > 1) ? $clog2(TH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic [FW-1:0] f_idx,
    output logic [CW-1:0] c_idx,
    output logic [HW-1:0] r_idx,
    output logic [3:0]    t_idx,
    output logic          row_final,
    output logic          done
);
    seq_state_t state;
    logic last_t, last_r, last_c, last_f, run_end;

    assign busy      = (state == SEQ_RUN);
    assign last_t    = (t_idx == 4'(NTAP-1));
    assign last_r    = (r_idx == HW'(TH-1));
    assign last_c    = (c_idx == CW'(CS-1));
    assign last_f    = (f_idx == FW'(KG-1));
    assign row_final = busy && last_t && last_c;
    assign run_end   = busy && last_t && last_r && last_c && last_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            f_idx <= '0;
            c_idx <= '0;
            r_idx <= '0;
            t_idx <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    state <= SEQ_RUN;
                    f_idx <= '0;
                    c_idx <= '0;
                    r_idx <= '0;
                    t_idx <= '0;
                end
            end else if (!last_t) begin
                t_idx <= t_idx + 4'd1;
            end else begin
                t_idx <= '0;
                if (!last_r) begin
                    r_idx <= r_idx + 1'b1;
                end else begin
                    r_idx <= '0;
                    if (!last_c) begin
                        c_idx <= c_idx + 1'b1;
                    end else begin
                        c_idx <= '0;
                        if (!last_f) begin
                            f_idx <= f_idx + 1'b1;
                        end else begin
                            f_idx <= '0;
                            state <= SEQ_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_after_end_R7: assert property (@(posedge clk) disable iff (rst)
        run_end |=> (done && !busy));
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !run_end) |=> (busy && (t_idx != 4'd0 || r_idx != '0 || c_idx != '0 || f_idx != '0)));
endmodule

// File: rtl/conv_tile_engine.sv
module conv_tile_engine
    import conv_pkg::*;
#(
    parameter int TW = 4,
    parameter int TH = 4,
    parameter int CS = 2,
    parameter int KG = 2,
    parameter int DW = 8,
    parameter int BW = 16,
    parameter int AW = 24,
    parameter int OW = 16,
    localparam int FW = (KG > 1) ? $clog2(KG) : 1,
    localparam int CW = (CS > 1) ? $clog2(CS) : 1,
    localparam int HW = (TH > 1) ? $clog2(TH) : 1,
    localparam int RW = $clog2(TH + 2),
    localparam int XW = $clog2(TW + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               first_slice,
    input  logic               last_slice,
    input  logic               in_we,
    input  logic [CW-1:0]      in_ch,
    input  logic [RW-1:0]      in_row,
    input  logic [XW-1:0]      in_col,
    input  logic [DW-1:0]      in_data,
    input  logic               w_we,
    input  logic [FW-1:0]      w_filt,
    input  logic [CW-1:0]      w_ch,
    input  logic [3:0]         w_tap,
    input  logic [DW-1:0]      w_data,
    input  logic               b_we,
    input  logic [FW-1:0]      b_filt,
    input  logic [BW-1:0]      b_data,
    output logic               done,
    output logic               out_vld,
    output logic [FW-1:0]      out_filt,
    output logic [HW-1:0]      out_row,
    output logic [TW*OW-1:0]   out_data
);
    localparam logic signed [AW-1:0] SAT_MAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};

    logic signed [DW-1:0] xbuf     [CS][TH+2][TW+2];
    logic signed [DW-1:0] wbuf     [KG][CS][NTAP];
    logic signed [BW-1:0] bias_mem [KG];
    logic signed [AW-1:0] psum     [KG][TH][TW];
    logic signed [AW-1:0] lane_sum [TW];
    logic [OW-1:0]        sat_val  [TW];

    slice_mode_t   mode_q;
    logic          busy, row_final, init_term;
    logic [FW-1:0] f_idx;
    logic [CW-1:0] c_idx;
    logic [HW-1:0] r_idx;
    logic [3:0]    t_idx;
    logic signed [DW-1:0] w_cur;

    function automatic logic [OW-1:0] relu_sat(input logic signed [AW-1:0] v);
        if (v < 0)
            return '0;
        else if (v > SAT_MAX)
            return SAT_MAX[OW-1:0];
        else
            return v[OW-1:0];
    endfunction

    conv_seq #(.KG(KG), .CS(CS), .TH(TH)) u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .f_idx(f_idx), .c_idx(c_idx), .r_idx(r_idx), .t_idx(t_idx),
        .row_final(row_final), .done(done)
    );

    // buffer write ports
    always_ff @(posedge clk) begin
        if (in_we) xbuf[in_ch][in_row][in_col] <= in_data;
        if (w_we)  wbuf[w_filt][w_ch][w_tap]   <= w_data;
        if (b_we)  bias_mem[b_filt]            <= b_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (!busy && start)
            mode_q <= '{first: first_slice, last: last_slice};
    end

    assign w_cur     = wbuf[f_idx][c_idx][t_idx];
    assign init_term = mode_q.first && (c_idx == '0) && (t_idx == 4'd0);

    for (genvar j = 0; j < TW; j++) begin : g_lane
        logic [RW-1:0] ra;
        logic [XW-1:0] ca;
        assign ra = RW'(r_idx) + RW'(tap_dy(t_idx));
        assign ca = XW'(j) + XW'(tap_dx(t_idx));

        mac_lane #(.DW(DW), .AW(AW), .BW(BW)) u_lane (
            .x(xbuf[c_idx][ra][ca]), .w(w_cur),
            .acc(psum[f_idx][r_idx][j]), .bias(bias_mem[f_idx]),
            .init(init_term), .sum(lane_sum[j])
        );
        assign sat_val[j] = relu_sat(lane_sum[j]);

        assert_relu_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
            out_vld |-> !out_data[j*OW + OW - 1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < KG; f++)
                for (int r = 0; r < TH; r++)
                    for (int j = 0; j < TW; j++)
                        psum[f][r][j] <= '0;
        end else if (busy) begin
            for (int j = 0; j < TW; j++)
                psum[f_idx][r_idx][j] <= lane_sum[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_filt <= '0;
            out_row  <= '0;
            out_data <= '0;
        end else begin
            out_vld <= row_final && mode_q.last;
            if (row_final) begin
                out_filt <= f_idx;
                out_row  <= r_idx;
                for (int j = 0; j < TW; j++)
                    out_data[j*OW +: OW] <= sat_val[j];
            end
        end
    end

    assert_no_vld_mid_R6: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> mode_q.last);
    assert_done_with_row_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_vld == mode_q.last));
    assert_row_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !done) |=> (!out_vld || out_row != $past(out_row) || out_filt != $past(out_filt)));
endmodule

// File: tb/conv_tile_engine_tb_top.sv
module conv_tile_engine_tb_top;
    localparam int TW = 4, TH = 4, CS = 2, KG = 2;
    localparam int LAT = KG * CS * TH * 9;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 0, first_slice = 0, last_slice = 0;
    logic in_we = 0, w_we = 0, b_we = 0;
    logic [0:0] in_ch = '0, w_filt = '0, w_ch = '0, b_filt = '0;
    logic [2:0] in_row = '0, in_col = '0;
    logic [3:0] w_tap = '0;
    logic [7:0] in_data = '0, w_data = '0;
    logic [15:0] b_data = '0;
    logic done, out_vld;
    logic [0:0] out_filt;
    logic [1:0] out_row;
    logic [TW*16-1:0] out_data;

    always #4 clk = ~clk;

    conv_tile_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .first_slice(first_slice), .last_slice(last_slice),
        .in_we(in_we), .in_ch(in_ch), .in_row(in_row), .in_col(in_col), .in_data(in_data),
        .w_we(w_we), .w_filt(w_filt), .w_ch(w_ch), .w_tap(w_tap), .w_data(w_data),
        .b_we(b_we), .b_filt(b_filt), .b_data(b_data),
        .done(done), .out_vld(out_vld), .out_filt(out_filt), .out_row(out_row), .out_data(out_data)
    );

    int checks = 0, errors = 0, cyc = 0;
    int xm [CS][TH+2][TW+2];
    int wm [KG][CS][9];
    int bm [KG];
    int acc [KG][TH][TW];
    int expo [KG][TH][TW];
    int vld_cnt = 0;
    bit run_last = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v < 0) return 0;
        if (v > 32767) return 32767;
        return v;
    endfunction

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    // R2 R5 R6: stream monitor, expected filter-major, rows ascending
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            int ef, er;
            ef = vld_cnt / TH;
            er = vld_cnt % TH;
            chk(run_last, "R6 strobe on non-last run", 1, 0);
            chk(int'(out_filt) == ef, "R5 filter order", int'(out_filt), ef);
            chk(int'(out_row) == er, "R5 row order", int'(out_row), er);
            for (int j = 0; j < TW; j++) begin
                int got;
                got = int'(out_data[j*16 +: 16]);
                if (ef < KG && er < TH)
                    chk(got == expo[ef][er][j], "R2/R4 lane value", got, expo[ef][er][j]);
            end
            vld_cnt++;
        end
    end

    // mode 0 small, 1 full range, 2 all-positive max, 3 opposing max
    task automatic load(input int mode, input bit with_bias);
        for (int c = 0; c < CS; c++)
            for (int r = 0; r < TH + 2; r++)
                for (int x = 0; x < TW + 2; x++) begin
                    int v;
                    v = (mode == 0) ? rnd(-8, 7) : (mode == 1) ? rnd(-128, 127) : 127;
                    xm[c][r][x] = v;
                    @(negedge clk);
                    in_we = 1; in_ch = 1'(c); in_row = 3'(r); in_col = 3'(x); in_data = 8'(v);
                end
        @(negedge clk); in_we = 0;
        for (int f = 0; f < KG; f++)
            for (int c = 0; c < CS; c++)
                for (int t = 0; t < 9; t++) begin
                    int v;
                    v = (mode == 0) ? rnd(-8, 7) : (mode == 1) ? rnd(-128, 127) : (mode == 2) ? 127 : -128;
                    wm[f][c][t] = v;
                    @(negedge clk);
                    w_we = 1; w_filt = 1'(f); w_ch = 1'(c); w_tap = 4'(t); w_data = 8'(v);
                end
        @(negedge clk); w_we = 0;
        if (with_bias) begin
            for (int f = 0; f < KG; f++) begin
                int v;
                v = (mode == 0) ? rnd(-300, 300) : rnd(-32768, 32767);
                bm[f] = v;
                @(negedge clk);
                b_we = 1; b_filt = 1'(f); b_data = 16'(v);
            end
            @(negedge clk); b_we = 0;
        end
    endtask

    task automatic run(input bit first, input bit last, input bit poke_mid, input string tag);
        int t0, guard;
        for (int f = 0; f < KG; f++)
            for (int i = 0; i < TH; i++)
                for (int j = 0; j < TW; j++) begin
                    int s;
                    s = 0;
                    for (int c = 0; c < CS; c++)
                        for (int t = 0; t < 9; t++)
                            s += xm[c][i + t / 3][j + t % 3] * wm[f][c][t];
                    acc[f][i][j] = (first ? bm[f] : acc[f][i][j]) + s;
                    expo[f][i][j] = sat(acc[f][i][j]);
                end
        vld_cnt = 0;
        run_last = last;
        @(negedge clk);
        start = 1; first_slice = first; last_slice = last;
        @(negedge clk);
        t0 = cyc;
        start = 0;
        if (poke_mid) begin
            repeat (20) @(negedge clk);
            start = 1; first_slice = ~first; last_slice = ~last;
            @(negedge clk);
            start = 0; first_slice = first; last_slice = last;
        end
        guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(done, {"R7 done seen ", tag}, int'(done), 1);
        chk(cyc - t0 == LAT, {"R7 latency ", tag}, cyc - t0, LAT);
        @(negedge clk);
        chk(!done, {"R7 single pulse ", tag}, int'(done), 0);
        repeat (2) @(negedge clk);
        chk(vld_cnt == (last ? KG * TH : 0), {"R5/R6/R8 strobe count ", tag}, vld_cnt, last ? KG * TH : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int f = 0; f < KG; f++)
            for (int i = 0; i < TH; i++)
                for (int j = 0; j < TW; j++) acc[f][i][j] = 0;
        repeat (3) @(negedge clk);
        chk(!done && !out_vld, "R1 outputs low in reset", int'(done) + int'(out_vld), 0);
        rst = 0;
        @(negedge clk);
        chk(!done && !out_vld, "R1 outputs low after reset", int'(done) + int'(out_vld), 0);

        // R1: sums start at zero; bias present but not used
        load(0, 1);
        run(0, 1, 0, "R1 zero start");
        // R2: single slice with bias
        load(0, 1);
        run(1, 1, 0, "R2 single");
        // R3 R6: two-slice chain, bias only once
        load(1, 1);
        run(1, 0, 0, "R6 first half");
        load(0, 0);
        run(0, 1, 0, "R3 second half");
        // R4: saturation high and clamp to zero
        load(2, 1);
        run(1, 1, 0, "R4 high");
        load(3, 1);
        run(1, 1, 0, "R4 zero");
        // R8: start poked mid-run inside a three-slice chain
        load(1, 1);
        run(1, 0, 0, "R3 chain a");
        load(1, 0);
        run(0, 0, 1, "R8 chain b");
        load(0, 0);
        run(0, 1, 1, "R8 chain c");
        // random two-slice chains
        for (int n = 0; n < 3; n++) begin
            load(1, 1);
            run(1, 0, 0, "R3 rand a");
            load(n % 2, 0);
            run(0, 1, 0, "R3 rand b");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule